// File: doc/BRIEF.md
# Bit-Serial PHY Tuning Write Engine

This block is a small hardware master that loads a multi-bit tuning value into the internal configuration space of one of several USB PHYs. The configuration space is reached through a single 32-bit control word. Each bit of the value is written one at a time. For every bit the engine first sets up an internal address and a data bit in the control word. It then raises and lowers a strobe bit that belongs to the selected PHY. The PHY latches the data bit on that pulse.

A request is a one-cycle `start` pulse that carries a PHY index, a base address, the value and a bit count. The engine holds `busy` while it works. Every change it makes to the control word is presented on `ctlWord`, qualified by a one-cycle `ctlWrEn`. A one-cycle `done` pulse closes the sequence. Some register layouts need the control word written to zero before the first bit. An input selects this behaviour per request.

Typical jobs are:
- transmit amplitude: base 0x20, 5 bits, value 0x14
- disconnect threshold: base 0x2a, 2 bits
- squelch detect: base 0x3c, 2 bits, value 0 to enable and 2 to disable
- resistor calibration: base 0x0c, 1 bit, value 1, requested for PHY 0 only

Top module: `phy_tune_serializer`

## Requirements
- R1: After reset, `ctlWord` is zero, and `ctlWrEn`, `busy` and `done` are low.
- R2: Bit i of the value is written to internal address (base+i) mod 256 in `ctlWord[15:8]`. Bits go least significant first, with exactly `bitLen` strobe pulses per request.
- R3: While the strobe is high, `ctlWord[7]` carries the value bit being delivered.
- R4: The strobe for PHY index p is `ctlWord[2*p]`. No other strobe position (the even bits below 7) is ever set.
- R5: Each bit takes three writes in order. The first sets the address and data with the strobe low. The second raises the strobe. The third lowers it. Address and data do not change across the second and third writes.
- R6: The strobe stays high for exactly STROBE_HOLD cycles (at least 1) per bit.
- R7: With `zeroFirst` high, the first write of a non-empty request is the all-zero word.
- R8: Busy and done behave as follows:
  - `busy` rises on the cycle after an accepted start.
  - `busy` stays high through a one-cycle `done` pulse.
  - `done` is followed by idle.
  - A `start` that arrives while `busy` is high is ignored.
- R9: A request with `bitLen` zero raises `done` on the cycle after the start, with no write at all.
- R10: Bit positions at or above the value width (VAL_W) are sent as 0.
- R11: A request of B bits has the following timing:
  - `done` appears 1 + Z + B*(STROBE_HOLD+2) cycles after the start edge, where Z is 1 when the zero write is made.
  - The amplitude, threshold, squelch and calibration jobs reassemble to their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request pulse, taken only when idle |
| phyIdx | input | $clog2(NUM_PHY) | Target PHY index |
| baseAddr | input | 8 | First internal address |
| value | input | VAL_W | Tuning value, LSB sent first |
| bitLen | input | LEN_W | Number of bits to send |
| zeroFirst | input | 1 | Write an all-zero word before the first bit |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| ctlWord | output | 32 | Current control word contents |
| ctlWrEn | output | 1 | `ctlWord` was written this cycle |

## Verification
The assertions assume three things about the inputs:
- `phyIdx` is below NUM_PHY.
- `start` is a single-cycle pulse.
- Nothing else modifies the control word, so strobe bits are only ever set by the engine.

The stimulus draws PHY indices only from the legal range and releases `start` on the following cycle. It also injects a deliberately foreign start in the middle of some sequences to exercise the ignore rule. The target model in the bench rebuilds each delivered value from the strobe edges it sees on `ctlWord`.

// File: rtl/tune_pkg.sv
`timescale 1ns/1ps
package tune_pkg;
  localparam int CTL_W    = 32;
  localparam int ADDR_W   = 8;
  localparam int ADDR_LSB = 8;
  localparam int DATA_POS = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_FIN
  } seqState_t;

  typedef struct packed {
    logic load;
    logic clear;
    logic setup;
    logic strobeHi;
    logic strobeLo;
  } dpCtl_t;
endpackage

// File: rtl/tune_ctrl.sv
`timescale 1ns/1ps
module tune_ctrl import tune_pkg::*; #(
  parameter int STROBE_HOLD = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   lenIsZero,
  input  logic   zeroFirst,
  input  logic   lastBit,
  output dpCtl_t ctl,
  output logic   busy,
  output logic   done
);
  localparam int HC_W = (STROBE_HOLD > 1) ? $clog2(STROBE_HOLD) : 1;
  localparam logic [HC_W-1:0] HOLD_LAST = HC_W'(STROBE_HOLD - 1);

  seqState_t state, nextState;
  logic [HC_W-1:0] holdCnt;

  always_comb begin
    nextState = state;
    ctl = '0;
    unique case (state)
      ST_IDLE: if (start) begin
        ctl.load = 1'b1;
        if (lenIsZero)      nextState = ST_FIN;
        else if (zeroFirst) nextState = ST_CLEAR;
        else                nextState = ST_SETUP;
      end
      ST_CLEAR: begin
        ctl.clear = 1'b1;
        nextState = ST_SETUP;
      end
      ST_SETUP: begin
        ctl.setup = 1'b1;
        nextState = ST_HIGH;
      end
      ST_HIGH: begin
        ctl.strobeHi = (holdCnt == '0);
        if (holdCnt == HOLD_LAST) nextState = ST_LOW;
      end
      ST_LOW: begin
        ctl.strobeLo = 1'b1;
        nextState = lastBit ? ST_FIN : ST_SETUP;
      end
      ST_FIN:  nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      holdCnt <= '0;
    end else begin
      state   <= nextState;
      holdCnt <= (state == ST_HIGH && nextState == ST_HIGH) ? holdCnt + 1'b1 : '0;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

  AST_DONE_SINGLE:  assert property (@(posedge clk) disable iff (!rstN) done |=> !done);  // R8
  AST_DONE_RETIRES: assert property (@(posedge clk) disable iff (!rstN) done |=> !busy);  // R8
  AST_BUSY_HELD:    assert property (@(posedge clk) disable iff (!rstN) (busy && !done) |=> busy);  // R8
  AST_ZERO_LEN:     assert property (@(posedge clk) disable iff (!rstN) (start && !busy && lenIsZero) |=> done);  // R9
  AST_HOLD_BOUND:   assert property (@(posedge clk) disable iff (!rstN) (state == ST_HIGH) |-> (holdCnt <= HOLD_LAST));  // R6
endmodule

// File: rtl/tune_dp.sv
`timescale 1ns/1ps
module tune_dp import tune_pkg::*; #(
  parameter int NUM_PHY = 4,
  parameter int VAL_W   = 8,
  parameter int LEN_W   = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic [IDX_W-1:0]   phyIdx,
  input  logic [ADDR_W-1:0]  baseAddr,
  input  logic [VAL_W-1:0]   value,
  input  logic [LEN_W-1:0]   bitLen,
  output logic [CTL_W-1:0]   ctlWord,
  output logic               ctlWrEn,
  output logic               lastBit
);
  function automatic logic [CTL_W-1:0] strobeField();
    logic [CTL_W-1:0] m;
    m = '0;
    for (int g = 0; g < NUM_PHY; g++) m[2*g] = 1'b1;
    return m;
  endfunction

  localparam logic [CTL_W-1:0] ALL_STB    = strobeField();
  localparam logic [CTL_W-1:0] ADDR_FIELD = CTL_W'({ADDR_W{1'b1}}) << ADDR_LSB;
  localparam logic [CTL_W-1:0] DATA_FIELD = CTL_W'(1) << DATA_POS;

  logic [IDX_W-1:0]  phyReg;
  logic [ADDR_W-1:0] baseReg;
  logic [VAL_W-1:0]  shiftReg;
  logic [LEN_W-1:0]  lenReg;
  logic [LEN_W-1:0]  bitIdx;
  logic [CTL_W-1:0]  wordReg;
  logic              wrReg;
  logic [NUM_PHY-1:0] phySel;
  logic [CTL_W-1:0]  selMask;
  logic [ADDR_W-1:0] curAddr;
  logic              curStb;

  for (genvar g = 0; g < NUM_PHY; g++) begin : g_sel
    assign phySel[g] = (phyReg == IDX_W'(g));
  end

  always_comb begin
    selMask = '0;
    for (int g = 0; g < NUM_PHY; g++) selMask[2*g] = phySel[g];
  end

  assign curAddr = baseReg + ADDR_W'(bitIdx);
  assign lastBit = (bitIdx == LEN_W'(lenReg - 1'b1));
  assign curStb  = |(wordReg & selMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phyReg   <= '0;
      baseReg  <= '0;
      shiftReg <= '0;
      lenReg   <= '0;
      bitIdx   <= '0;
      wordReg  <= '0;
      wrReg    <= 1'b0;
    end else begin
      wrReg <= ctl.clear | ctl.setup | ctl.strobeHi | ctl.strobeLo;
      if (ctl.load) begin
        phyReg   <= phyIdx;
        baseReg  <= baseAddr;
        shiftReg <= value;
        lenReg   <= bitLen;
        bitIdx   <= '0;
      end
      if (ctl.clear) wordReg <= '0;
      if (ctl.setup)
        wordReg <= (wordReg & ~(selMask | ADDR_FIELD | DATA_FIELD))
                 | (CTL_W'(curAddr) << ADDR_LSB)
                 | (CTL_W'(shiftReg[0]) << DATA_POS);
      if (ctl.strobeHi) wordReg <= wordReg | selMask;
      if (ctl.strobeLo) begin
        wordReg  <= wordReg & ~selMask;
        bitIdx   <= bitIdx + 1'b1;
        shiftReg <= shiftReg >> 1;
      end
    end
  end

  assign ctlWord = wordReg;
  assign ctlWrEn = wrReg;

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN) $onehot0(wordReg & ALL_STB));  // R4
  AST_RISE_STABLE:   assert property (@(posedge clk) disable iff (!rstN) $rose(curStb) |-> $stable(wordReg[15:7]));  // R5
  AST_FALL_STABLE:   assert property (@(posedge clk) disable iff (!rstN) $fell(curStb) |-> $stable(wordReg[15:7]));  // R5
  AST_STROBE_WRITTEN: assert property (@(posedge clk) disable iff (!rstN) $changed(curStb) |-> wrReg);  // R5
endmodule

// File: rtl/phy_tune_serializer.sv
`timescale 1ns/1ps
module phy_tune_serializer import tune_pkg::*; #(
  parameter int NUM_PHY     = 4,
  parameter int VAL_W       = 8,
  parameter int LEN_W       = 4,
  parameter int STROBE_HOLD = 2,
  localparam int IDX_W      = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [IDX_W-1:0]   phyIdx,
  input  logic [7:0]         baseAddr,
  input  logic [VAL_W-1:0]   value,
  input  logic [LEN_W-1:0]   bitLen,
  input  logic               zeroFirst,
  output logic               busy,
  output logic               done,
  output logic [31:0]        ctlWord,
  output logic               ctlWrEn
);
  dpCtl_t dpCtl;
  logic   lastBit;

  tune_ctrl #(.STROBE_HOLD(STROBE_HOLD)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .lenIsZero(bitLen == '0), .zeroFirst(zeroFirst), .lastBit(lastBit),
    .ctl(dpCtl), .busy(busy), .done(done)
  );

  tune_dp #(.NUM_PHY(NUM_PHY), .VAL_W(VAL_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(dpCtl), .phyIdx(phyIdx), .baseAddr(baseAddr),
    .value(value), .bitLen(bitLen), .ctlWord(ctlWord), .ctlWrEn(ctlWrEn),
    .lastBit(lastBit)
  );
endmodule

// File: tb/test_phy_tune_serializer.sv
`timescale 1ns/1ps
module test_phy_tune_serializer;
  localparam int NUM_PHY = 4;
  localparam int VAL_W   = 8;
  localparam int LEN_W   = 4;
  localparam int HOLD    = 2;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, zeroFirst = 1'b0;
  logic [1:0] phyIdx = '0;
  logic [7:0] baseAddr = '0;
  logic [VAL_W-1:0] value = '0;
  logic [LEN_W-1:0] bitLen = '0;
  logic busy, done, ctlWrEn;
  logic [31:0] ctlWord;

  always #5 clk = ~clk;

  phy_tune_serializer #(.NUM_PHY(NUM_PHY), .VAL_W(VAL_W), .LEN_W(LEN_W), .STROBE_HOLD(HOLD))
    i_phy_tune_serializer (
      .clk(clk), .rstN(rstN), .start(start), .phyIdx(phyIdx), .baseAddr(baseAddr),
      .value(value), .bitLen(bitLen), .zeroFirst(zeroFirst), .busy(busy), .done(done),
      .ctlWord(ctlWord), .ctlWrEn(ctlWrEn));

  int nChecks = 0, nFails = 0;

  // target model state
  int curPhy = 0;
  int nWr = 0, nStb = 0, hiCnt = 0;
  logic [31:0] firstWord = '0, prevWord = '0;
  logic [7:0] addrLog [64];
  logic dataLog [64];
  int hiLen [64];
  bit seqErr = 0, otherErr = 0;

  function automatic logic [31:0] otherMask(int p);
    logic [31:0] m = '0;
    for (int g = 0; g < NUM_PHY; g++) if (g != p) m[2*g] = 1'b1;
    return m;
  endfunction

  function automatic logic expBit(int v, int i);
    return (i < VAL_W) ? v[i] : 1'b0;
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      if (ctlWrEn) begin
        if (nWr == 0) firstWord = ctlWord;
        if ((ctlWord & otherMask(curPhy)) != 0) otherErr = 1;
        if (ctlWord[2*curPhy] && !prevWord[2*curPhy]) begin
          if (prevWord[15:7] !== ctlWord[15:7] || nWr == 0) seqErr = 1;
          if (nStb < 64) begin
            addrLog[nStb] = ctlWord[15:8];
            dataLog[nStb] = ctlWord[7];
          end
          nStb++;
        end else if (!ctlWord[2*curPhy] && prevWord[2*curPhy]) begin
          if (prevWord[15:7] !== ctlWord[15:7]) seqErr = 1;
          if (nStb > 0 && nStb <= 64) hiLen[nStb-1] = hiCnt;
          hiCnt = 0;
        end
        prevWord = ctlWord;
        nWr++;
      end
      if (ctlWord[2*curPhy]) hiCnt++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic runJob(input int phy, input int base, input int val, input int len,
                        input bit zf, input bit inject);
    int lat = 0;
    int expLat;
    bit addrOk = 1, dataOk = 1, holdOk = 1;
    expLat = (len == 0) ? 1 : 1 + (zf ? 1 : 0) + len * (HOLD + 2);
    curPhy = phy; nWr = 0; nStb = 0; hiCnt = 0; seqErr = 0; otherErr = 0;
    phyIdx = 2'(phy); baseAddr = 8'(base); value = VAL_W'(val);
    bitLen = LEN_W'(len); zeroFirst = zf; start = 1'b1;
    for (int k = 1; k <= 300; k++) begin
      @(negedge clk);
      if (k == 1) begin
        start = 1'b0;
        check(busy === 1'b1, "R8", "busy after start", busy, 1);
      end
      if (inject && k == 3) begin
        start = 1'b1; phyIdx = 2'(phy + 1); baseAddr = ~8'(base);
        value = ~VAL_W'(val); bitLen = '1;
      end
      if (inject && k == 4) start = 1'b0;
      if (done === 1'b1) begin
        lat = k;
        break;
      end
    end
    check(lat == expLat, "R11", "done latency", lat, expLat);
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R8", "idle after done", {busy, done}, 0);
    check(nStb == len, "R2", "strobe count", nStb, len);
    check(nWr == (len == 0 ? 0 : (zf ? 1 : 0) + 3 * len), "R9", "write count", nWr,
          (len == 0 ? 0 : (zf ? 1 : 0) + 3 * len));
    for (int i = 0; i < len && i < nStb; i++) begin
      if (addrLog[i] !== 8'(base + i)) addrOk = 0;
      if (dataLog[i] !== expBit(val, i)) dataOk = 0;
      if (hiLen[i] != HOLD) holdOk = 0;
    end
    check(addrOk, "R2", "address sequence", base, base);
    check(dataOk, (len > VAL_W) ? "R10" : "R3", "data bits", val, val);
    check(holdOk, "R6", "strobe high width", hiLen[0], HOLD);
    check(!otherErr, "R4", "foreign strobe set", otherErr, 0);
    check(!seqErr, "R5", "setup/high/low order", seqErr, 0);
    if (zf && len > 0) check(firstWord == 0, "R7", "zero first word", firstWord, 0);
  endtask

  initial begin
    #1500000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    check(ctlWord == 0 && !busy && !done && !ctlWrEn, "R1", "reset state",
          {ctlWord, busy, done, ctlWrEn}, 0);
    rstN = 1'b1;
    @(negedge clk);
    // directed tuning jobs (R11)
    runJob(1, 8'h20, 8'h14, 5, 1'b1, 1'b0);   // amplitude
    runJob(2, 8'h2a, 3, 2, 1'b0, 1'b0);       // disconnect threshold
    runJob(0, 8'h3c, 0, 2, 1'b1, 1'b0);       // squelch enable
    runJob(3, 8'h3c, 2, 2, 1'b1, 1'b0);       // squelch disable
    runJob(0, 8'h0c, 1, 1, 1'b0, 1'b0);       // calibration, PHY 0 only
    runJob(2, 8'h55, 8'hff, 0, 1'b1, 1'b0);   // R9 zero length
    runJob(1, 8'h10, 8'hff, 12, 1'b0, 1'b0);  // R10 beyond width
    runJob(3, 8'hfe, 8'h0a, 4, 1'b1, 1'b0);   // R2 address wrap
    runJob(0, 8'h40, 8'h5a, 6, 1'b0, 1'b1);   // R8 start ignored
    for (int n = 0; n < 40; n++)
      runJob(int'($urandom % NUM_PHY), int'($urandom % 256), int'($urandom % 256),
             int'($urandom % 16), 1'($urandom), 1'($urandom));
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule